// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD counters. A one-cycle tick pulse, expected at 100 Hz from an external prescaler, advances a hundredths-of-second counter. Its carry ripples through seconds, minutes, hours, date, month and a two-digit year in the same cycle. A three-bit weekday counter steps whenever the day changes. It counts on its own and does not depend on the date value. The hour can be kept in 24-hour form or in 12-hour form with a PM flag, and the choice is stored with the hour itself.

Software sets the time through a write channel. It names one field with a code and supplies a byte. Every field is visible in parallel on the output ports at all times. The write channel uses valid/ready signalling, but the block never applies back-pressure: `wr_ready_o` is always high, so a write is taken in every cycle where `wr_valid_i` is high. Any accepted write restarts the hundredths counter at 00, which aligns the new second to the write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs are: hundredths 00, seconds 00, minutes 00, hour 8'h12 (12-hour mode, AM, twelve o'clock), date 01, month 01, year 00 and weekday 0.
- R2: Each tick advances the hundredths count by one in BCD from 00 up to the parameter HSEC_LAST (default 8'h99). A tick at HSEC_LAST returns the count to 00 and advances the seconds by one.
- R3: Seconds and minutes count 00 to 59 in BCD. Stepping past 59 returns to 00 and carries into the next field in the same cycle.
- R4: Hour byte format in 24-hour mode: bit 7 = 1, bit 6 = 0, bits 5:0 hold a BCD value 00 to 23. A step from 23 gives 8'h80 and advances the day.
- R5: Hour byte format in 12-hour mode: bit 7 = 0, bit 6 = 0, bit 5 = PM (1 = PM), bits 4:0 hold a BCD value 01 to 12. A step from 11 gives 12 and toggles PM. A step from 12 gives 01 and leaves PM unchanged. The day advances only on the step from 11 PM to 12 AM.
- R6: On a day advance, the date returns to 01 and the month advances when the date was the last day of its month. Months 04, 06, 09 and 11 have 30 days, February is covered by R7, and all other months have 31 days.
- R7: February ends on 29 when the year value is divisible by 4, and on 28 otherwise.
- R8: When the month advances past 12 it returns to 01 and the year advances. The year wraps from 99 to 00.
- R9: The weekday is 3 bits wide. It steps once on every day advance in the order 0,1,...,6 and then back to 0, regardless of the date.
- R10: Field codes: 1 seconds, 2 minutes, 3 hour (the byte format of R4/R5, where bit 7 selects the mode), 4 date, 5 month, 6 year, 7 weekday (bits 2:0). An accepted write with one of these codes loads the byte into that field and clears the hundredths to 00. A tick in that same cycle is ignored.
- R11: A write with code 0 (hundredths) changes nothing. A tick in that cycle acts as if no write were present.
- R12: In a cycle with no tick and no write, every output holds its value.
- R13: `wr_ready_o` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per hundredth of a second |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write accept, always high |
| wr_field_i | input | 3 | Field code of the write |
| wr_data_i | input | 8 | Byte to load |
| hsec_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with mode and PM flags |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| wday_o | output | 3 | Weekday 0 to 6 |

## Verification
The bench builds the block with HSEC_LAST = 8'h04, so one second takes five ticks instead of one hundred. Combined with writes that preset seconds and minutes to 59, this brings every carry through hour, day, month and year within a few cycles. Preset dates then cover the month ends in both a leap year and a common year, the December-to-January turn with the 99-to-00 year wrap, both 12-hour boundaries, and the weekday wrap from 6 back to 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BCD_W  = 8;
  localparam int WDAY_W = 3;
  localparam int CODE_W = 3;

  localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

  typedef enum logic [CODE_W-1:0] {
    FLD_HSEC  = 3'd0,
    FLD_SEC   = 3'd1,
    FLD_MIN   = 3'd2,
    FLD_HOUR  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_WDAY  = 3'd7
  } rtc_field_e;

  // Two-digit BCD increment; callers handle the wrap themselves.
  function automatic logic [BCD_W-1:0] bcd_inc(input logic [BCD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four for a two-digit BCD value.
  function automatic logic bcd_div4(input logic [BCD_W-1:0] y);
    if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [BCD_W-1:0] FIRST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             wrap_i,
  input  logic             load_i,
  input  logic [BCD_W-1:0] load_val_i,
  output logic [BCD_W-1:0] value_o
);

  logic [BCD_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= FIRST;
    else if (load_i) val_q <= load_val_i;
    else if (step_i) val_q <= wrap_i ? FIRST : bcd_inc(val_q);
  end

  assign value_o = val_q;

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       load_i,
  input  logic [6:0] load_val_i,   // {mode24, value bits 5:0}
  output logic [7:0] hour_o,
  output logic       day_o
);

  logic       mode24_q;
  logic       pm_q;
  logic [5:0] val_q;
  logic       last24;
  logic       last12;

  function automatic logic [5:0] inc6(input logic [5:0] v);
    if (v[3:0] == 4'd9) return {v[5:4] + 2'd1, 4'd0};
    else                return {v[5:4], v[3:0] + 4'd1};
  endfunction

  assign last24 = (val_q == 6'h23);
  assign last12 = (val_q == 6'h11) && pm_q;
  assign day_o  = step_i && (mode24_q ? last24 : last12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode24_q <= 1'b0;
      pm_q     <= 1'b0;
      val_q    <= 6'h12;
    end else if (load_i) begin
      mode24_q <= load_val_i[6];
      if (load_val_i[6]) begin
        pm_q  <= 1'b0;
        val_q <= load_val_i[5:0];
      end else begin
        pm_q  <= load_val_i[5];
        val_q <= {1'b0, load_val_i[4:0]};
      end
    end else if (step_i) begin
      if (mode24_q) begin
        val_q <= last24 ? 6'h00 : inc6(val_q);
      end else if (val_q == 6'h12) begin
        val_q <= 6'h01;
      end else if (val_q == 6'h11) begin
        val_q <= 6'h12;
        pm_q  <= ~pm_q;
      end else begin
        val_q <= inc6(val_q);
      end
    end
  end

  assign hour_o = mode24_q ? {2'b10, val_q} : {2'b00, pm_q, val_q[4:0]};

endmodule

// File: rtl/rtc_month_end.sv
module rtc_month_end
  import rtc_pkg::*;
(
  input  logic [BCD_W-1:0] month_i,
  input  logic [BCD_W-1:0] year_i,
  output logic [BCD_W-1:0] last_o
);

  always_comb begin
    case (month_i)
      8'h02:                      last_o = bcd_div4(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter logic [7:0] HSEC_LAST = 8'h99
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [2:0]  wr_field_i,
  input  logic [7:0]  wr_data_i,
  output logic [7:0]  hsec_o,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  date_o,
  output logic [7:0]  month_o,
  output logic [7:0]  year_o,
  output logic [2:0]  wday_o
);

  localparam int   LOW_FIELDS = 2;            // seconds and minutes
  localparam logic [BCD_W-1:0] LOW_LAST = 8'h59;

  logic wr_acc;
  logic step_base;
  logic hsec_wrap;
  logic [LOW_FIELDS:0] chain;
  logic [BCD_W-1:0] low_val [LOW_FIELDS];
  logic day_step;
  logic month_step;
  logic year_step;
  logic [BCD_W-1:0] date_last;
  logic [WDAY_W-1:0] wday_q;

  assign wr_ready_o = 1'b1;
  assign wr_acc     = wr_valid_i && (wr_field_i != FLD_HSEC);
  assign step_base  = tick_i && !wr_acc;

  // Hundredths: any accepted write reloads it with zero.
  assign hsec_wrap = (hsec_o == HSEC_LAST);
  rtc_bcd_field #(.FIRST(8'h00)) u_hsec (
    .clk(clk), .rst_n(rst_n),
    .step_i(step_base), .wrap_i(hsec_wrap),
    .load_i(wr_acc), .load_val_i(8'h00),
    .value_o(hsec_o)
  );
  assign chain[0] = step_base && hsec_wrap;

  // Seconds then minutes, both base sixty.
  for (genvar k = 0; k < LOW_FIELDS; k++) begin : g_low
    localparam logic [CODE_W-1:0] CODE = CODE_W'(int'(FLD_SEC) + k);
    logic wrap_k;
    assign wrap_k = (low_val[k] == LOW_LAST);
    rtc_bcd_field #(.FIRST(8'h00)) u_fld (
      .clk(clk), .rst_n(rst_n),
      .step_i(chain[k]), .wrap_i(wrap_k),
      .load_i(wr_valid_i && (wr_field_i == CODE)),
      .load_val_i(wr_data_i),
      .value_o(low_val[k])
    );
    assign chain[k+1] = chain[k] && wrap_k;
  end
  assign sec_o = low_val[0];
  assign min_o = low_val[1];

  rtc_hour_field u_hour (
    .clk(clk), .rst_n(rst_n),
    .step_i(chain[LOW_FIELDS]),
    .load_i(wr_valid_i && (wr_field_i == FLD_HOUR)),
    .load_val_i({wr_data_i[7], wr_data_i[5:0]}),
    .hour_o(hour_o),
    .day_o(day_step)
  );

  rtc_month_end u_mend (.month_i(month_o), .year_i(year_o), .last_o(date_last));

  rtc_bcd_field #(.FIRST(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n),
    .step_i(day_step), .wrap_i(date_o == date_last),
    .load_i(wr_valid_i && (wr_field_i == FLD_DATE)),
    .load_val_i(wr_data_i),
    .value_o(date_o)
  );
  assign month_step = day_step && (date_o == date_last);

  rtc_bcd_field #(.FIRST(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n),
    .step_i(month_step), .wrap_i(month_o == 8'h12),
    .load_i(wr_valid_i && (wr_field_i == FLD_MONTH)),
    .load_val_i(wr_data_i),
    .value_o(month_o)
  );
  assign year_step = month_step && (month_o == 8'h12);

  rtc_bcd_field #(.FIRST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n),
    .step_i(year_step), .wrap_i(year_o == 8'h99),
    .load_i(wr_valid_i && (wr_field_i == FLD_YEAR)),
    .load_val_i(wr_data_i),
    .value_o(year_o)
  );

  // Weekday: free-running modulo seven, driven only by the day carry.
  always_ff @(posedge clk) begin
    if (!rst_n)
      wday_q <= '0;
    else if (wr_valid_i && (wr_field_i == FLD_WDAY))
      wday_q <= wr_data_i[WDAY_W-1:0];
    else if (day_step)
      wday_q <= (wday_q == WDAY_LAST) ? '0 : wday_q + 1'b1;
  end
  assign wday_o = wday_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter logic [7:0] HSEC_LAST = 8'h99
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_valid_i,
  input logic [2:0] wr_field_i,
  input logic [7:0] hsec_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] wday_o,
  input logic       day_step
);

  logic [58:0] snap;
  assign snap = {hsec_o, sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o};

  // R2
  hsec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsec_o <= HSEC_LAST);

  // R10
  wr_clears_hsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_field_i != 3'd0) |=> (hsec_o == 8'h00));

  // R11
  hsec_code_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_field_i == 3'd0 && !tick_i) |=> $stable(snap));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid_i && !tick_i) |=> $stable(snap));

  // R9
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && wday_o == 3'd6) |=> (wday_o == 3'd0));

  // R4
  hour24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && hour_o == 8'hA3) |=> (hour_o == 8'h80));

endmodule

bind rtc_calendar rtc_calendar_chk #(.HSEC_LAST(HSEC_LAST)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
  .wr_valid_i(wr_valid_i), .wr_field_i(wr_field_i),
  .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .date_o(date_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o),
  .day_step(day_step)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;

  localparam logic [7:0] HSL = 8'h04;
  localparam int HSL_INT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic       wr_ready_o;
  logic [2:0] wr_field_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] hsec_o, sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] wday_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtc_calendar #(.HSEC_LAST(HSL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_field_i(wr_field_i), .wr_data_i(wr_data_i),
    .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o)
  );

  // Reference state, plain integers.
  int m_hs, m_s, m_m, m_hr, m_date, m_mon, m_yr, m_wd;
  bit m_24;

  typedef struct {
    logic [58:0] val;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_days(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [58:0] model_snap();
    logic [7:0] hb, t;
    int h12;
    if (m_24) begin
      t  = to_bcd(m_hr);
      hb = {2'b10, t[5:0]};
    end else begin
      h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
      t   = to_bcd(h12);
      hb  = {2'b00, (m_hr >= 12), t[4:0]};
    end
    return {to_bcd(m_hs), to_bcd(m_s), to_bcd(m_m), hb, to_bcd(m_date),
            to_bcd(m_mon), to_bcd(m_yr), 3'(m_wd)};
  endfunction

  task automatic model_reset();
    m_hs = 0; m_s = 0; m_m = 0; m_hr = 0; m_24 = 0;
    m_date = 1; m_mon = 1; m_yr = 0; m_wd = 0;
  endtask

  task automatic model_tick();
    m_hs++;
    if (m_hs > HSL_INT) begin
      m_hs = 0; m_s++;
      if (m_s > 59) begin
        m_s = 0; m_m++;
        if (m_m > 59) begin
          m_m = 0; m_hr++;
          if (m_hr > 23) begin
            m_hr = 0;
            m_wd = (m_wd + 1) % 7;
            m_date++;
            if (m_date > month_days(m_mon, m_yr)) begin
              m_date = 1; m_mon++;
              if (m_mon > 12) begin
                m_mon = 1;
                m_yr = (m_yr + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic model_write(int code, logic [7:0] d);
    int h12;
    if (code == 0) return;
    m_hs = 0;
    case (code)
      1: m_s = from_bcd(d);
      2: m_m = from_bcd(d);
      3: begin
        m_24 = d[7];
        if (d[7]) m_hr = from_bcd({2'b00, d[5:0]});
        else begin
          h12  = from_bcd({3'b000, d[4:0]});
          m_hr = (h12 % 12) + (d[5] ? 12 : 0);
        end
      end
      4: m_date = from_bcd(d);
      5: m_mon = from_bcd(d);
      6: m_yr = from_bcd(d);
      default: m_wd = int'(d[2:0]);
    endcase
  endtask

  // Driver: one clock cycle of stimulus, expected result pushed when chk is set.
  task automatic cyc(bit tk, bit wv, int code, logic [7:0] d, bit chk, string req);
    exp_t e;
    @(negedge clk);
    tick_i = tk; wr_valid_i = wv; wr_field_i = 3'(code); wr_data_i = d;
    @(posedge clk);
    #1;
    if (wv && code != 0) model_write(code, d);
    else if (tk) model_tick();
    if (chk) begin
      e.val = model_snap();
      e.req = req;
      sb_q.push_back(e);
    end
  endtask

  task automatic wr(int code, logic [7:0] d);
    cyc(1'b0, 1'b1, code, d, 1'b0, "");
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 8'h00, (i == n - 1), req);
  endtask

  // Preset an hour with minutes and seconds at 59, then step into the next hour.
  task automatic roll_hour(logic [7:0] hb, string req);
    wr(3, hb);
    wr(2, 8'h59);
    wr(1, 8'h59);
    ticks(HSL_INT + 1, req);
  endtask

  // Monitor: pops the scoreboard between clock edges.
  always @(negedge clk) begin
    exp_t e;
    logic [58:0] act;
    if (sb_q.size() > 0) begin
      e   = sb_q.pop_front();
      act = {hsec_o, sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o};
      checks++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", e.req, act, e.val);
      end
    end
  end

  initial begin
    exp_t e;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    e.val = model_snap(); e.req = "R1"; sb_q.push_back(e);
    @(negedge clk);
    checks++;
    if (wr_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R13 actual=%b expected=1", wr_ready_o);
    end

    // R2 hundredths counting and carry
    ticks(1, "R2"); ticks(1, "R2"); ticks(1, "R2");
    ticks(2, "R2");

    // R10 write with simultaneous tick
    cyc(1'b1, 1'b1, 1, 8'h59, 1'b1, "R10");
    wr(2, 8'h59);
    // R3 seconds and minutes roll into the hour
    ticks(HSL_INT + 1, "R3");

    // R12 idle cycles
    cyc(1'b0, 1'b0, 0, 8'h00, 1'b1, "R12");
    cyc(1'b0, 1'b0, 0, 8'h00, 1'b1, "R12");

    // R11 write with hundredths code
    ticks(2, "R2");
    cyc(1'b0, 1'b1, 0, 8'h55, 1'b1, "R11");
    cyc(1'b1, 1'b1, 0, 8'h33, 1'b1, "R11");

    // R5 12-hour boundaries
    roll_hour(8'h11, "R5");          // 11 AM -> 12 PM
    wr(2, 8'h59); wr(1, 8'h59);
    ticks(HSL_INT + 1, "R5");        // 12 PM -> 01 PM
    roll_hour(8'h31, "R5");          // 11 PM -> 12 AM, date and weekday step

    // R4 24-hour mode
    roll_hour(8'hA2, "R4");
    wr(4, 8'h28); wr(5, 8'h02); wr(6, 8'h23);
    roll_hour(8'hA3, "R7");          // Feb 28 common year -> Mar 01
    cyc(1'b0, 1'b0, 0, 8'h00, 1'b1, "R4");

    // R7 leap February
    wr(4, 8'h28); wr(5, 8'h02); wr(6, 8'h24);
    roll_hour(8'hA3, "R7");          // -> Feb 29
    roll_hour(8'hA3, "R7");          // -> Mar 01

    // R6 month lengths
    wr(4, 8'h30); wr(5, 8'h04);
    roll_hour(8'hA3, "R6");          // Apr 30 -> May 01
    wr(4, 8'h31); wr(5, 8'h01);
    roll_hour(8'hA3, "R6");          // Jan 31 -> Feb 01
    wr(4, 8'h30); wr(5, 8'h05);
    roll_hour(8'hA3, "R6");          // May 30 -> May 31

    // R8 year turn
    wr(4, 8'h31); wr(5, 8'h12); wr(6, 8'h99);
    roll_hour(8'hA3, "R8");
    wr(4, 8'h31); wr(5, 8'h12); wr(6, 8'h12);
    roll_hour(8'hA3, "R8");

    // R9 weekday load and wrap
    cyc(1'b0, 1'b1, 7, 8'h05, 1'b1, "R9");
    wr(7, 8'h06);
    roll_hour(8'hA3, "R9");

    // R10 mode switch back to 12-hour through the hour write
    cyc(1'b0, 1'b1, 3, 8'h25, 1'b1, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (wr_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R13 actual=%b expected=1", wr_ready_o);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule